// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Transmitter

This block sends bytes over a two-wire synchronous link made of a data line and a serial clock. It has two storage stages. Software, or any upstream producer, hands a byte to a holding register through a valid/ready write port. When the shifter is free, the byte moves into the shift register and goes out least significant bit first, one bit per serial clock period. The serial clock is either generated inside the block from a programmable half-period count, or taken from an external pin that is first passed through a synchronizer.

Two flags report progress. The holding-empty flag says the holding register can take a byte. The end flag says the link has stopped. Each flag has its own enable that turns it into an interrupt request. During the last bit of a frame the block looks at the holding register. If a byte is waiting, the next frame follows with no gap. Otherwise the link stops, the clock stays high and the data line keeps the level of the last bit sent.

The write port follows stream rules. `wr_ready` is high exactly while the holding register is empty. A byte is taken on a clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, `wr_valid` and `wr_data` are ignored. The producer may hold `wr_valid` high for as long as it likes, and data is never dropped or overwritten.

Top module: `sync_ser_tx`

## Requirements
- R1: `wr_ready` equals the holding-empty flag. An accepted write stores `wr_data` and clears both the holding-empty flag and the end flag on that edge, and the end flag loses to a write that lands on the same edge. A `wr_valid` that arrives while `wr_ready` is low has no effect and its byte is never sent.
- R2: After reset, `txd` is 1, `sclk_out` is 1, `tdr_empty` is 1, `tx_end` is 1 and `wr_ready` is 1.
- R3: When the shifter is idle and the holding register is full, the byte moves to the shift register on the next edge and `tdr_empty` returns to 1.
- R4: Each frame carries 8 data bits on `txd`, bit 0 first and bit 7 last.
- R5: With `ext_clk_sel` = 0 (internal clock), each frame produces exactly 8 clock pulses on `sclk_out`. Each pulse is low for the first half of the bit and high for the second. Each half lasts `half_cnt` system clocks, and values below 2 act as 2. `txd` changes only while `sclk_out` is low.
- R6: With `ext_clk_sel` = 1 (external clock), `sclk_out` stays at 1. `txd` moves to the next bit after each falling edge of the synchronized `sclk_in`, and the receiver samples on its rising edge.
- R7: If the holding register is full when the rising edge of bit 7 is processed, that byte is loaded and the next frame starts with no idle gap. With the internal clock, the rising edges of consecutive bits stay exactly 2 x half-period apart across the frame boundary.
- R8: If the holding register is empty at that point, `tx_end` goes to 1 while `tdr_empty` is 1. `sclk_out` then stays at 1 and `txd` keeps the level of bit 7 until the next accepted write.
- R9: `txi_req` is `tdr_empty` AND `tx_int_en`, and `tei_req` is `tx_end` AND `end_int_en`, both held as levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_sel | input | 1 | 0: generate serial clock, 1: follow `sclk_in` |
| half_cnt | input | HALF_W | System clocks per half bit, internal mode (min 2) |
| tx_int_en | input | 1 | Enable for the data-empty request |
| end_int_en | input | 1 | Enable for the transmit-end request |
| wr_valid | input | 1 | Producer offers a byte |
| wr_data | input | DATA_W | Byte to send |
| wr_ready | output | 1 | Holding register can take a byte |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Generated serial clock, idles high |
| txd | output | 1 | Serial data |
| tdr_empty | output | 1 | Holding-empty flag |
| tx_end | output | 1 | Transmit-end flag |
| txi_req | output | 1 | Data-empty interrupt request |
| tei_req | output | 1 | Transmit-end interrupt request |

## Verification
The bench reassembles each frame from `txd`, sampling on every rising serial clock edge, and compares it with the bytes it wrote. A reversed bit order or a ninth pulse shows up as a wrong byte or a wrong bit count. Back-to-back bursts are timed edge by edge, so a design that adds a gap between frames, or skips the final check and stops early, produces a stretched interval or a missing byte. Writes offered while the port is not ready must leave no trace in the output stream. At the end of each burst the bench checks that the data line has stayed at bit 7 rather than returning to 1, and that the external-clock mode never toggles `sclk_out`.

// File: rtl/sst_pkg.sv
`timescale 1ns/1ps
package sst_pkg;
  typedef enum logic {
    CLK_INT = 1'b0,
    CLK_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/sst_sclk_gen.sv
`timescale 1ns/1ps
// Internal serial clock: low half then high half, one toggle per half period.
module sst_sclk_gen #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_cnt,
  output logic              sclk,
  output logic              fall_tick,
  output logic              rise_tick
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] reload;

  // half periods below two are stretched to two
  always_comb begin
    if (half_cnt < HALF_W'(2)) reload = HALF_W'(1);
    else                       reload = half_cnt - HALF_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk      <= 1'b1;
      cnt       <= '0;
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
    end else begin
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      if (!run) begin
        sclk <= 1'b1;
        cnt  <= '0;
      end else if (cnt == '0) begin
        sclk      <= ~sclk;
        cnt       <= reload;
        fall_tick <= sclk;
        rise_tick <= ~sclk;
      end else begin
        cnt <= cnt - HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/sst_edge_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer on the external serial clock plus edge detection.
module sst_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic fall_tick,
  output logic rise_tick
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= sclk_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall_tick = prev_q & ~sync_q;
  assign rise_tick = ~prev_q & sync_q;
endmodule

// File: rtl/sst_hold_reg.sv
`timescale 1ns/1ps
// Holding register with the empty and end flags.
module sst_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  input  logic              finish,
  output logic              wr_ready,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty,
  output logic              end_flag
);
  assign wr_ready = empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data <= '0;
      empty     <= 1'b1;
      end_flag  <= 1'b1;
    end else if (wr_valid && empty) begin
      // an accepted write outranks a simultaneous stop
      hold_data <= wr_data;
      empty     <= 1'b0;
      end_flag  <= 1'b0;
    end else begin
      if (take)   empty    <= 1'b1;
      if (finish) end_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/sst_shift_core.sv
`timescale 1ns/1ps
// Shift register, bit counter and the last-bit continue/stop decision.
module sst_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              fall_tick,
  input  logic              rise_tick,
  output logic              take,
  output logic              finish,
  output logic              active,
  output logic              txd
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic              last_rise;

  assign last_rise = active & rise_tick & (bit_q == LAST_BIT);
  assign take      = hold_full & (~active | last_rise);
  assign finish    = last_rise & ~hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      active <= 1'b0;
      txd    <= 1'b1;
    end else if (take) begin
      sh_q   <= hold_data;
      bit_q  <= '0;
      active <= 1'b1;
    end else if (finish) begin
      active <= 1'b0;
    end else if (active) begin
      if (fall_tick) begin
        txd  <= sh_q[0];
        sh_q <= sh_q >> 1;
      end
      if (rise_tick) bit_q <= bit_q + BIT_W'(1);
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
`timescale 1ns/1ps
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_sel,
  input  logic [HALF_W-1:0] half_cnt,
  input  logic              tx_int_en,
  input  logic              end_int_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              txd,
  output logic              tdr_empty,
  output logic              tx_end,
  output logic              txi_req,
  output logic              tei_req
);
  clk_src_e          src;
  logic              int_fall, int_rise, ext_fall, ext_rise;
  logic              fall_tick, rise_tick;
  logic              take, finish, active;
  logic [DATA_W-1:0] hold_data;
  logic              empty, end_flag;

  assign src = clk_src_e'(ext_clk_sel);

  sst_sclk_gen #(.HALF_W(HALF_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (active && (src == CLK_INT)),
    .half_cnt  (half_cnt),
    .sclk      (sclk_out),
    .fall_tick (int_fall),
    .rise_tick (int_rise)
  );

  sst_edge_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_in   (sclk_in),
    .fall_tick (ext_fall),
    .rise_tick (ext_rise)
  );

  always_comb begin
    if (src == CLK_EXT) begin
      fall_tick = ext_fall;
      rise_tick = ext_rise;
    end else begin
      fall_tick = int_fall;
      rise_tick = int_rise;
    end
  end

  sst_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .take      (take),
    .finish    (finish),
    .wr_ready  (wr_ready),
    .hold_data (hold_data),
    .empty     (empty),
    .end_flag  (end_flag)
  );

  sst_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_full (~empty),
    .hold_data (hold_data),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .take      (take),
    .finish    (finish),
    .active    (active),
    .txd       (txd)
  );

  assign tdr_empty = empty;
  assign tx_end    = end_flag;
  assign txi_req   = empty & tx_int_en;
  assign tei_req   = end_flag & end_int_en;
endmodule

// File: rtl/sst_checker.sv
`timescale 1ns/1ps
module sst_checker (
  input logic clk,
  input logic rst_n,
  input logic ext_clk_sel,
  input logic wr_valid,
  input logic wr_ready,
  input logic sclk_out,
  input logic txd,
  input logic tdr_empty,
  input logic tx_end
);
  // R1: an accepted write leaves both flags cleared
  a_r1_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!tx_end && !tdr_empty));

  // R5: with the internal clock, data moves only while the clock is low
  a_r5_data_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_clk_sel && $stable(ext_clk_sel) && !$stable(txd)) |-> !sclk_out);

  // R6: no generated clock in external mode
  a_r6_no_clock_out: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_sel && $past(ext_clk_sel)) |-> sclk_out);

  // R8: stopping happens with the holding register empty and the clock high
  a_r8_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_end) |-> (tdr_empty && sclk_out));

  // R8: the line keeps its level while stopped
  a_r8_line_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && !(wr_valid && wr_ready)) |=> $stable(txd));
endmodule

bind sync_ser_tx sst_checker u_sst_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_clk_sel (ext_clk_sel),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .sclk_out    (sclk_out),
  .txd         (txd),
  .tdr_empty   (tdr_empty),
  .tx_end      (tx_end)
);

// File: tb/sync_ser_tx_bench.sv
`timescale 1ns/1ps
module sync_ser_tx_bench;
  localparam int DATA_W = 8;
  localparam int HALF_W = 8;
  localparam int EXT_HALF = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ext_clk_sel = 1'b0;
  logic [HALF_W-1:0] half_cnt = HALF_W'(3);
  logic              tx_int_en = 1'b1;
  logic              end_int_en = 1'b1;
  logic              wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_ready;
  logic              sclk_in = 1'b1;
  logic              sclk_out, txd, tdr_empty, tx_end, txi_req, tei_req;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  cap_on = 1'b0;
  bit  started = 1'b0;
  bit  rxq[$];
  longint stamps[$];
  logic [7:0] expq[$];
  int  ext_falls = 0;

  always #2 clk = ~clk;

  sync_ser_tx #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_sync_ser_tx (
    .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .half_cnt(half_cnt),
    .tx_int_en(tx_int_en), .end_int_en(end_int_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .txd(txd), .tdr_empty(tdr_empty), .tx_end(tx_end),
    .txi_req(txi_req), .tei_req(tei_req)
  );

  // receiver model for the generated clock: sample on rising edge
  always @(posedge sclk_out) begin
    if (cap_on && !ext_clk_sel) begin
      rxq.push_back(txd);
      stamps.push_back(longint'($time));
    end
  end

  always @(negedge sclk_out) begin
    if (cap_on && ext_clk_sel) ext_falls++;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_half(int h);
    return (h < 2) ? 2 : h;
  endfunction

  task automatic write_byte(logic [7:0] b);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
    check(!tdr_empty && !tx_end, "R1", "flags after write",
          {tdr_empty, tx_end}, 0);
  endtask

  task automatic junk_offer();
    // holding register is full here: these offers must be ignored
    wr_valid = 1'b1;
    wr_data  = 8'h99;
    repeat (3) @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic ext_pulses(int n);
    wait (started);
    repeat (4) @(negedge clk);
    for (int p = 0; p < n; p++) begin
      sclk_in = 1'b0;
      repeat (EXT_HALF) @(negedge clk);
      rxq.push_back(txd);
      sclk_in = 1'b1;
      repeat (EXT_HALF) @(negedge clk);
    end
  endtask

  task automatic ext_writer(bit junk);
    for (int j = 0; j < expq.size(); j++) begin
      write_byte(expq[j]);
      started = 1'b1;
      if (junk && j == 1) junk_offer();
    end
  endtask

  task automatic run_burst(bit ext, int h, bit junk);
    int nb;
    logic [7:0] got;
    nb = expq.size();
    ext_clk_sel = ext;
    half_cnt = HALF_W'(h);
    rxq.delete();
    stamps.delete();
    ext_falls = 0;
    started = 1'b0;
    cap_on = 1'b1;
    @(negedge clk);
    if (!ext) begin
      for (int j = 0; j < nb; j++) begin
        write_byte(expq[j]);
        if (junk && j == 1) junk_offer();
      end
    end else begin
      fork
        ext_writer(junk);
        ext_pulses(8 * nb);
      join
    end
    while (!tx_end) @(negedge clk);
    repeat (3) @(negedge clk);
    cap_on = 1'b0;
    check(rxq.size() == 8 * nb, "R1", "bit count (no extra or lost byte)",
          rxq.size(), 8 * nb);
    for (int j = 0; j < nb; j++) begin
      got = '0;
      for (int i = 0; i < 8; i++)
        if (8 * j + i < rxq.size()) got[i] = rxq[8 * j + i];
      check(got == expq[j], "R4", "received byte", got, expq[j]);
    end
    if (!ext) begin
      for (int k = 1; k < stamps.size(); k++)
        check(stamps[k] - stamps[k-1] == longint'(8 * eff_half(h)), "R7",
              "rise interval ns", stamps[k] - stamps[k-1], 8 * eff_half(h));
    end else begin
      check(ext_falls == 0, "R6", "sclk_out toggles in external mode", ext_falls, 0);
    end
    check(tx_end == 1'b1, "R8", "end flag after burst", tx_end, 1);
    check(txd == expq[nb-1][7], "R8", "line held at bit 7", txd, expq[nb-1][7]);
    check(sclk_out == 1'b1, "R8", "clock held high", sclk_out, 1);
    check(tei_req == (tx_end & end_int_en), "R9", "tei_req level", tei_req,
          tx_end & end_int_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    check(txd == 1'b1, "R2", "txd after reset", txd, 1);
    check(sclk_out == 1'b1, "R2", "sclk_out after reset", sclk_out, 1);
    check(tdr_empty == 1'b1, "R2", "tdr_empty after reset", tdr_empty, 1);
    check(tx_end == 1'b1, "R2", "tx_end after reset", tx_end, 1);
    check(wr_ready == 1'b1, "R2", "wr_ready after reset", wr_ready, 1);
    check(txi_req == 1'b1 && tei_req == 1'b1, "R9", "requests enabled",
          {txi_req, tei_req}, 3);
    tx_int_en = 1'b0;
    end_int_en = 1'b0;
    @(negedge clk);
    check(txi_req == 1'b0 && tei_req == 1'b0, "R9", "requests masked",
          {txi_req, tei_req}, 0);
    tx_int_en = 1'b1;

    // R3: single transfer from idle, watched cycle by cycle
    half_cnt = HALF_W'(3);
    cap_on = 1'b1;
    rxq.delete();
    stamps.delete();
    wr_valid = 1'b1;
    wr_data = 8'h35;
    @(negedge clk);
    wr_valid = 1'b0;
    check(tdr_empty == 1'b0 && txi_req == 1'b0, "R3", "full after write",
          {tdr_empty, txi_req}, 0);
    @(negedge clk);
    check(tdr_empty == 1'b1, "R3", "empty after transfer", tdr_empty, 1);
    check(txi_req == 1'b1, "R9", "txi_req after transfer", txi_req, 1);
    while (!tx_end) @(negedge clk);
    repeat (3) @(negedge clk);
    cap_on = 1'b0;
    check(rxq.size() == 8, "R5", "pulses per frame", rxq.size(), 8);
    check(stamps.size() > 1 && stamps[1] - stamps[0] == 24, "R5", "bit period ns",
          stamps.size() > 1 ? stamps[1] - stamps[0] : 0, 24);
    check(txd == 1'b0, "R8", "held at bit 7 of 0x35", txd, 0);
    check(tei_req == 1'b0, "R9", "tei_req masked", tei_req, 0);
    end_int_en = 1'b1;

    // R7: back to back, half count 1 stretched to 2, with ignored offers (R1)
    expq = '{8'h5A, 8'hC3, 8'h81};
    run_burst(1'b0, 1, 1'b1);

    // R6: external clock burst
    expq = '{8'hE1, 8'h0F};
    run_burst(1'b1, 4, 1'b1);

    // random bursts
    for (int r = 0; r < 20; r++) begin
      int len;
      expq.delete();
      len = $urandom_range(1, 3);
      for (int j = 0; j < len; j++) expq.push_back(8'($urandom_range(0, 255)));
      end_int_en = 1'($urandom_range(0, 1));
      run_burst(1'($urandom_range(0, 1)), $urandom_range(0, 6), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule